// File: doc/BRIEF.md
# ADC Input Multiplexer Sequencer

This block paces a single shared delta-sigma converter across a small set of analog inputs. It runs on a 32768 Hz clock. Two settings shape each pass. A two-bit channel-count code chooses how many inputs are visited, and a one-bit length setting chooses whether each conversion takes two or three clock periods. Every pass opens with one extra period. In that period the block pulses a start strobe for a downstream computation engine and samples the settings for the pass that follows. The channel slots then follow in ascending order.

Within each slot the block does four things:
- It drives the channel select.
- It pulses a conversion-start strobe toward the decimation filter in the slot's first period.
- It pulses a capture strobe together with a raw-data write address in the slot's last period.
- It holds a reference-chopping level that flips at every pass boundary.

A rising edge on the alternate-cycle request is latched, so a one-period pulse is never lost. The request then takes effect at the next pass boundary, for exactly one pass. During that pass every slot is flagged as alternate, and its samples land in a separate address window. An illegal channel-count code leaves the previous setting in force and sets a sticky error flag.

Top module: `adc_mux_seq`

## Requirements
- R1: The channel-count code selects the channels per pass: code 01 gives 4 channels, code 10 gives 3 and code 11 gives 2. The channel select steps through 0, 1, ... up to N-1 in ascending order, one value per slot, and is 0 in the pass-start period.
- R2: With the length setting at 0 a slot lasts 2 clock periods, and with it at 1 a slot lasts 3. The conversion-start strobe is high only in the first period of a slot. The capture strobe is high only in the last period of a slot.
- R3: A pass lasts N*T+1 periods, where T is the slot length. The pass-start strobe is high in exactly one period per pass, and that period comes before the first slot.
- R4: The code and length inputs are sampled only in the pass-start period and govern the slots that follow it. Changes at any other time do not alter the pass in progress.
- R5: Code 00 sampled in a pass-start period leaves both the previous channel count and the previous length in force. It also sets the error flag, which then stays high until reset.
- R6: While the capture strobe is high, the write address equals the channel index, plus 4 when the pass is an alternate pass.
- R7: A rising edge on the alternate request, even a one-period pulse, is latched. If the edge arrives in or before a pass-start period, the pass that begins there becomes alternate. Exactly one pass is alternate per edge, even if the request stays high. The alternate flag is high in every slot period of that pass and low in pass-start periods.
- R8: The chop output is 0 after reset. It inverts on entry to each pass-start period after the first, and it is constant for the rest of the pass.
- R9: In the first period after reset the pass-start strobe is high, and the channel select, both conversion strobes, the alternate flag, the chop output and the error flag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_code_i | input | 2 | Channel-count code (01:4, 10:3, 11:2, 00 illegal) |
| long_conv_i | input | 1 | Conversion length, 0: 2 periods, 1: 3 periods |
| alt_req_i | input | 1 | Alternate-cycle request, rising-edge sensitive |
| ch_sel_o | output | 2 | Multiplexer channel select |
| conv_start_o | output | 1 | Filter conversion-start strobe |
| cap_strobe_o | output | 1 | Raw-data capture strobe |
| cap_addr_o | output | 3 | Raw-data write address |
| alt_slot_o | output | 1 | Current slot belongs to an alternate pass |
| chop_o | output | 1 | Reference chopping polarity |
| pass_start_o | output | 1 | Computation-engine pass-start strobe |
| cfg_err_o | output | 1 | Sticky illegal-code flag |

## Verification
The bench first runs each of the six legal code and length combinations for whole passes. This separates the pass length, slot length and channel order of each setting from its neighbours. Directed sequences then change the settings mid-pass, send a one-period alternate pulse mid-pass, and send one in the pass-start period itself. They also hold the request high across several passes and program the illegal code. These show deferral at the boundary, edge capture, the one-pass limit and holding of the previous setting. A long random phase mixes setting changes with sparse request pulses, so that edges fall at every slot position and on every code.

// File: rtl/adc_mux_pkg.sv
package adc_mux_pkg;

    localparam int CNT_W  = 3;
    localparam int TICK_W = 2;

    typedef struct packed {
        logic [CNT_W-1:0] nch;
        logic             long_conv;
    } mux_cfg_t;

    typedef struct packed {
        mux_cfg_t cfg;
        logic     err;
    } cfg_state_t;

    typedef struct packed {
        logic prev;
        logic pend;
        logic active;
    } alt_state_t;

    function automatic logic [CNT_W-1:0] code_to_count(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            2'b01:   n = CNT_W'(4);
            2'b10:   n = CNT_W'(3);
            2'b11:   n = CNT_W'(2);
            default: n = CNT_W'(4);
        endcase
        return n;
    endfunction

    function automatic logic [TICK_W-1:0] last_tick(input logic long_conv);
        return long_conv ? TICK_W'(2) : TICK_W'(1);
    endfunction

endpackage

// File: rtl/mux_cfg_reg.sv
module mux_cfg_reg
    import adc_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] code_i,
    input  logic       long_i,
    output mux_cfg_t   cfg_o,
    output logic       err_o
);

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            if (code_i != 2'b00) begin
                s_d.cfg.nch       = code_to_count(code_i);
                s_d.cfg.long_conv = long_i;
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cfg.nch       <= CNT_W'(4);
            s_q.cfg.long_conv <= 1'b0;
            s_q.err           <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o = s_q.cfg;
    assign err_o = s_q.err;

    AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o.nch >= CNT_W'(2)) && (cfg_o.nch <= CNT_W'(4))); // R1
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R5
    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && code_i == 2'b00) |=> ($stable(cfg_o) && err_o)); // R5
    AST_CFG_ONLY_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cfg_o)); // R4

endmodule

// File: rtl/alt_req_latch.sv
module alt_req_latch
    import adc_mux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic load_i,
    output logic active_o
);

    alt_state_t s_d, s_q;
    logic       rise;

    assign rise = req_i & ~s_q.prev;

    always_comb begin
        s_d      = s_q;
        s_d.prev = req_i;
        if (load_i) begin
            s_d.active = s_q.pend | rise;
            s_d.pend   = 1'b0;
        end else if (rise) begin
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o = s_q.active;

    AST_ALT_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !load_i) |=> s_q.pend); // R7
    AST_ALT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(active_o)); // R7
    AST_ALT_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !s_q.pend); // R7

endmodule

// File: rtl/mux_slot_core.sv
module mux_slot_core
    import adc_mux_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  mux_cfg_t        cfg_i,
    output logic            gap_o,
    output logic [CH_W-1:0] slot_o,
    output logic            conv_start_o,
    output logic            cap_o,
    output logic            chop_o
);

    typedef struct packed {
        logic              gap;
        logic [CH_W-1:0]   slot;
        logic [TICK_W-1:0] tick;
        logic              chop;
    } core_state_t;

    core_state_t s_d, s_q;
    logic        slot_done;
    logic        pass_done;

    assign slot_done = (s_q.tick == last_tick(cfg_i.long_conv));
    assign pass_done = slot_done && (CNT_W'(s_q.slot) == cfg_i.nch - CNT_W'(1));

    always_comb begin
        s_d = s_q;
        if (s_q.gap) begin
            s_d.gap  = 1'b0;
            s_d.slot = '0;
            s_d.tick = '0;
        end else if (pass_done) begin
            s_d.gap  = 1'b1;
            s_d.slot = '0;
            s_d.tick = '0;
            s_d.chop = ~s_q.chop;
        end else if (slot_done) begin
            s_d.slot = s_q.slot + CH_W'(1);
            s_d.tick = '0;
        end else begin
            s_d.tick = s_q.tick + TICK_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.gap  <= 1'b1;
            s_q.slot <= '0;
            s_q.tick <= '0;
            s_q.chop <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gap_o        = s_q.gap;
    assign slot_o       = s_q.gap ? '0 : s_q.slot;
    assign conv_start_o = !s_q.gap && (s_q.tick == '0);
    assign cap_o        = !s_q.gap && slot_done;
    assign chop_o       = s_q.chop;

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !gap_o |-> (CNT_W'(s_q.slot) < cfg_i.nch)); // R1
    AST_CONV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o); // R2
    AST_GAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        gap_o |=> (!gap_o && conv_start_o)); // R3
    AST_CHOP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !gap_o |-> $stable(chop_o)); // R8

endmodule

// File: rtl/adc_mux_seq.sv
module adc_mux_seq
    import adc_mux_pkg::*;
#(
    parameter int CH_MAX   = 4,
    parameter int ALT_BASE = CH_MAX,
    parameter int CH_W     = $clog2(CH_MAX),
    parameter int ADDR_W   = $clog2(ALT_BASE + CH_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        chan_code_i,
    input  logic              long_conv_i,
    input  logic              alt_req_i,
    output logic [CH_W-1:0]   ch_sel_o,
    output logic              conv_start_o,
    output logic              cap_strobe_o,
    output logic [ADDR_W-1:0] cap_addr_o,
    output logic              alt_slot_o,
    output logic              chop_o,
    output logic              pass_start_o,
    output logic              cfg_err_o
);

    mux_cfg_t cfg;
    logic     gap;
    logic     alt_active;

    mux_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (gap),
        .code_i (chan_code_i),
        .long_i (long_conv_i),
        .cfg_o  (cfg),
        .err_o  (cfg_err_o)
    );

    alt_req_latch u_alt (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (alt_req_i),
        .load_i   (gap),
        .active_o (alt_active)
    );

    mux_slot_core #(.CH_W(CH_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_i        (cfg),
        .gap_o        (gap),
        .slot_o       (ch_sel_o),
        .conv_start_o (conv_start_o),
        .cap_o        (cap_strobe_o),
        .chop_o       (chop_o)
    );

    assign pass_start_o = gap;
    assign alt_slot_o   = alt_active & ~gap;
    assign cap_addr_o   = ADDR_W'(ch_sel_o) + (alt_active ? ADDR_W'(ALT_BASE) : '0);

    AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe_o |-> (alt_slot_o == (cap_addr_o >= ADDR_W'(ALT_BASE)))); // R6
    AST_ALT_NOT_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        pass_start_o |-> !alt_slot_o); // R7
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        pass_start_o |-> (!conv_start_o && !cap_strobe_o)); // R3

endmodule

// File: tb/adc_mux_seq_tb.sv
module adc_mux_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk;
    logic       rst_n;
    logic [1:0] chan_code;
    logic       long_conv;
    logic       alt_req;
    logic [1:0] ch_sel;
    logic       conv_start;
    logic       cap_strobe;
    logic [2:0] cap_addr;
    logic       alt_slot;
    logic       chop;
    logic       pass_start;
    logic       cfg_err;

    int checks;
    int fails;
    bit done;

    int m_pos, m_n, m_t, m_err, m_chop, m_pend, m_alt, m_prev;

    adc_mux_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_code_i  (chan_code),
        .long_conv_i  (long_conv),
        .alt_req_i    (alt_req),
        .ch_sel_o     (ch_sel),
        .conv_start_o (conv_start),
        .cap_strobe_o (cap_strobe),
        .cap_addr_o   (cap_addr),
        .alt_slot_o   (alt_slot),
        .chop_o       (chop),
        .pass_start_o (pass_start),
        .cfg_err_o    (cfg_err)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int count_of(input logic [1:0] code);
        return (code == 2'b01) ? 4 : (code == 2'b10) ? 3 : 2;
    endfunction

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit gap;
        int slot, tick;
        gap  = (m_pos == 0);
        slot = gap ? 0 : (m_pos - 1) / m_t;
        tick = gap ? 0 : (m_pos - 1) % m_t;
        chk(pass_start, gap, "R3 pass_start");
        chk(ch_sel, slot, "R1 ch_sel");
        chk(conv_start, !gap && tick == 0, "R2 conv_start");
        chk(cap_strobe, !gap && tick == m_t - 1, "R2 cap_strobe");
        if (cap_strobe) chk(cap_addr, slot + (m_alt != 0 ? 4 : 0), "R6 cap_addr");
        chk(alt_slot, (m_alt != 0) && !gap, "R7 alt_slot");
        chk(chop, m_chop, "R8 chop");
        chk(cfg_err, m_err, "R5 cfg_err");
    endtask

    task automatic step(input logic [1:0] code, input logic lg, input logic req);
        bit rise;
        chan_code = code;
        long_conv = lg;
        alt_req   = req;
        compare_all();
        rise = req && (m_prev == 0);
        if (m_pos == 0) begin
            if (code != 2'b00) begin
                m_n = count_of(code);
                m_t = lg ? 3 : 2;
            end else begin
                m_err = 1;
            end
            m_alt  = (m_pend != 0 || rise) ? 1 : 0;
            m_pend = 0;
            m_pos  = 1;
        end else begin
            if (rise) m_pend = 1;
            if (m_pos == m_n * m_t) begin
                m_pos  = 0;
                m_chop = 1 - m_chop;
            end else begin
                m_pos++;
            end
        end
        m_prev = req;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_to_gap(input logic [1:0] code, input logic lg);
        while (!pass_start) step(code, lg, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        int alt_passes;
        logic [1:0] rc;
        logic rl;
        checks = 0; fails = 0; done = 1'b0;
        rst_n = 1'b0; chan_code = 2'b01; long_conv = 1'b0; alt_req = 1'b0;
        m_pos = 0; m_n = 4; m_t = 2; m_err = 0; m_chop = 0; m_pend = 0; m_alt = 0; m_prev = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state in first period
        chk(pass_start, 1, "R9 pass_start");
        chk(ch_sel, 0, "R9 ch_sel");
        chk(conv_start | cap_strobe, 0, "R9 strobes");
        chk(alt_slot, 0, "R9 alt_slot");
        chk(chop, 0, "R9 chop");
        chk(cfg_err, 0, "R9 cfg_err");

        // R1 R2 R3: every legal setting, measured pass length
        for (int c = 1; c < 4; c++) begin
            for (int l = 0; l < 2; l++) begin
                run_to_gap(2'(c), 1'(l));
                for (int p = 0; p < 2; p++) begin
                    step(2'(c), 1'(l), 1'b0);
                    cnt = 1;
                    while (!pass_start) begin step(2'(c), 1'(l), 1'b0); cnt++; end
                    chk(cnt, count_of(2'(c)) * (l ? 3 : 2) + 1, "R3 pass length");
                end
            end
        end

        // R4: mid-pass change does not alter the current pass
        run_to_gap(2'b11, 1'b0);
        step(2'b11, 1'b0, 1'b0);
        cnt = 1;
        while (!pass_start) begin step(2'b01, 1'b1, 1'b0); cnt++; end
        chk(cnt, 5, "R4 old pass length kept");
        step(2'b01, 1'b1, 1'b0);
        cnt = 1;
        while (!pass_start) begin step(2'b10, 1'b0, 1'b0); cnt++; end
        chk(cnt, 13, "R4 new pass length");

        // R7: one-period pulse mid-pass -> next pass alternate only
        step(2'b10, 1'b0, 1'b0);
        step(2'b10, 1'b0, 1'b1);
        alt_passes = 0;
        for (int p = 0; p < 3; p++) begin
            run_to_gap(2'b10, 1'b0);
            step(2'b10, 1'b0, 1'b0);
            if (alt_slot) alt_passes++;
        end
        chk(alt_passes, 1, "R7 single alternate pass");

        // R7: pulse in the pass-start period applies to that pass
        run_to_gap(2'b10, 1'b1);
        step(2'b10, 1'b1, 1'b1);
        chk(alt_slot, 1, "R7 edge in pass-start period");
        step(2'b10, 1'b1, 1'b0);

        // R7: request held high over several passes
        alt_passes = 0;
        for (int p = 0; p < 4; p++) begin
            step(2'b10, 1'b1, 1'b1);
            while (!pass_start) step(2'b10, 1'b1, 1'b1);
            step(2'b10, 1'b1, 1'b1);
            if (alt_slot) alt_passes++;
            while (!pass_start) step(2'b10, 1'b1, 1'b1);
        end
        chk(alt_passes, 1, "R7 held request");
        run_to_gap(2'b10, 1'b1);

        // R5: illegal code holds previous setting
        step(2'b00, 1'b0, 1'b0);
        chk(cfg_err, 1, "R5 err set");
        cnt = 1;
        while (!pass_start) begin step(2'b00, 1'b0, 1'b0); cnt++; end
        chk(cnt, 10, "R5 previous setting held");

        // random phase
        rc = 2'b01; rl = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 40 == 0) rc = 2'($urandom % 4);
            if ($urandom % 50 == 0) rl = 1'($urandom % 2);
            step(rc, rl, ($urandom % 9 == 0) ? 1'b1 : 1'b0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule